// File: doc/BRIEF.md
# Stopwatch Lap Counter

This block keeps a three-digit decimal stopwatch count and lets a processor read it four bits at a time over a narrow bus. Each digit holds a value from 0 to 9 and passes a carry to the next digit up when it rolls over. A one-cycle tick input advances the count while the run level is high. A clear strobe zeroes the count.

A lap strobe copies the running count into a capture buffer, and the processor can read that buffer through the same nibble port as the live count. Three sticky flags tell software what happened. The renewal flag marks fresh lap data. The carry-owed flag marks a lap taken on the tick that wrapped the top digit, so the captured value is one carry short in the next time unit. The interrupt flag is raised each time the full count wraps. Software clears the carry-owed flag and the interrupt flag with their own strobes. Clearing the stopwatch leaves the interrupt flag untouched.

A read of the lowest nibble copies the upper nibbles of the selected source into a shadow register. Reads of the middle and top nibbles then return that frozen copy, so a value read as three nibbles stays coherent while the count keeps moving.

Top module: `swatch_lap`

## Requirements
- R1: After a synchronous reset the count, the capture buffer, `rd_data_o`, `renew_o`, `carry_req_o` and `irq_o` are all zero.
- R2: On a cycle with `tick_i` and `run_i` high and `clr_i` low, the count goes up by one in BCD. Digit 0 is bits 3:0, digit 1 is bits 7:4 and digit 2 is bits 11:8. A digit at 9 goes back to 0 and carries into the next digit, and 999 wraps to 000.
- R3: While `run_i` is low, ticks have no effect on the count. Lap capture and reads keep working.
- R4: `clr_i` sets the count to 000 on the next edge and overrides a tick in the same cycle. It leaves `irq_o` unchanged.
- R5: A counting tick at 999 sets `irq_o` on the next edge. `irq_clr_i` clears it, and a wrap in the same cycle as the clear wins.
- R6: `lap_i` loads the capture buffer with the count as it stood before that cycle's edge. This happens whatever the value of `run_i`.
- R7: `renew_o` is set by `lap_i`. It is cleared by a read of nibble 2 of the capture buffer. A lap in the same cycle as that read wins.
- R8: `carry_req_o` is set when `lap_i` falls on a counting tick at 999. `carry_clr_i` clears it, and a set in the same cycle wins.
- R9: With `rd_en_i` high, `rd_src_i` picks the source: 0 for the live count, 1 for the capture buffer. The nibble select code does the following: 0 returns digit 0 and copies digits 1 and 2 of the source into a shadow; 1 returns shadow digit 1; 2 returns shadow digit 2; 3 returns 0. The result appears on `rd_data_o` one edge after the request.
- R10: `rd_data_o` holds its value on cycles without `rd_en_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle stopwatch advance pulse |
| run_i | input | 1 | Counting enable level |
| clr_i | input | 1 | Zero the count |
| lap_i | input | 1 | Capture the count into the lap buffer |
| irq_clr_i | input | 1 | Clear the interrupt flag |
| carry_clr_i | input | 1 | Clear the carry-owed flag |
| rd_en_i | input | 1 | Nibble read request |
| rd_src_i | input | 1 | Read source: 0 live, 1 lap buffer |
| rd_sel_i | input | 2 | Nibble select |
| rd_data_o | output | 4 | Registered read data |
| renew_o | output | 1 | Lap buffer holds unread new data |
| carry_req_o | output | 1 | Lap was taken on the wrapping tick |
| irq_o | output | 1 | Interrupt factor, set on count wrap |

## Verification
Three kinds of event can fall on the same edge. A lap can coincide with the tick that wraps 999 to 000. A clear strobe can coincide with a set source: a flag clear with the wrap, or a buffer nibble-2 read with a new lap. The bench runs the count up to 999 and fires the lap, or the flag clear, on the very tick that wraps. It also issues a buffer top-nibble read together with a lap. The flags are judged on the following edge against a bench model in which the set always wins and the captured value is the pre-wrap 999. A constrained-random phase then mixes clears, laps, flag clears and reads of both sources, so these collisions also occur unplanned.

// File: rtl/swatch_pkg.sv
package swatch_pkg;
  localparam int NIB_W    = 4;
  localparam int BCD_LAST = 9;

  typedef logic [NIB_W-1:0] nib_t;

  typedef enum logic [1:0] {
    SRC_LIVE = 2'd0,
    SRC_LAP  = 2'd1
  } rd_src_e;
endpackage

// File: rtl/swatch_bcd_digit.sv
module swatch_bcd_digit
  import swatch_pkg::*;
#(
  parameter int W = NIB_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q,
  output logic         carry
);
  localparam logic [W-1:0] LAST = W'(BCD_LAST);

  assign carry = inc && (q == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      q <= '0;
    end else if (inc) begin
      if (carry) q <= '0;
      else       q <= q + W'(1);
    end
  end
endmodule

// File: rtl/swatch_lap_unit.sv
module swatch_lap_unit #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          lap,
  input  logic          wrap,
  input  logic          hi_read,
  input  logic          carry_clr,
  input  logic [CW-1:0] cnt,
  output logic [CW-1:0] lap_buf,
  output logic          renew,
  output logic          carry_req
);
  always_ff @(posedge clk) begin
    if (rst) begin
      lap_buf   <= '0;
      renew     <= 1'b0;
      carry_req <= 1'b0;
    end else begin
      if (lap) lap_buf <= cnt;

      if (lap)          renew <= 1'b1;
      else if (hi_read) renew <= 1'b0;

      if (lap && wrap)    carry_req <= 1'b1;
      else if (carry_clr) carry_req <= 1'b0;
    end
  end
endmodule

// File: rtl/swatch_read_stage.sv
module swatch_read_stage #(
  parameter int DIGITS = 3,
  parameter int W      = 4,
  parameter int SEL_W  = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  rd_en,
  input  logic                  rd_src,
  input  logic [SEL_W-1:0]      rd_sel,
  input  logic [DIGITS*W-1:0]   live,
  input  logic [DIGITS*W-1:0]   lap_buf,
  output logic [W-1:0]          rd_data,
  output logic                  hi_read
);
  localparam int SH_W = (DIGITS - 1) * W;

  logic [DIGITS*W-1:0] src_val;
  logic [SH_W-1:0]     shadow_q;
  logic [W-1:0]        pick;

  assign src_val = rd_src ? lap_buf : live;
  assign hi_read = rd_en && rd_src && (rd_sel == SEL_W'(DIGITS - 1));

  always_comb begin
    pick = '0;
    if (rd_sel == '0) begin
      pick = src_val[W-1:0];
    end
    for (int k = 1; k < DIGITS; k++) begin
      if (rd_sel == SEL_W'(k)) pick = shadow_q[(k-1)*W +: W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= '0;
      rd_data  <= '0;
    end else if (rd_en) begin
      rd_data <= pick;
      if (rd_sel == '0) shadow_q <= src_val[DIGITS*W-1:W];
    end
  end
endmodule

// File: rtl/swatch_lap.sv
module swatch_lap
  import swatch_pkg::*;
#(
  parameter int DIGITS = 3,
  parameter int W      = NIB_W,
  parameter int SEL_W  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic             lap_i,
  input  logic             irq_clr_i,
  input  logic             carry_clr_i,
  input  logic             rd_en_i,
  input  logic             rd_src_i,
  input  logic [SEL_W-1:0] rd_sel_i,
  output logic [W-1:0]     rd_data_o,
  output logic             renew_o,
  output logic             carry_req_o,
  output logic             irq_o
);
  localparam int CW = DIGITS * W;

  logic [CW-1:0]     cnt_q;
  logic [CW-1:0]     lap_buf_q;
  logic [DIGITS:0]   chain;
  logic              wrap;
  logic              hi_read;

  assign chain[0] = tick_i && run_i && !clr_i;
  assign wrap     = chain[DIGITS];

  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    swatch_bcd_digit #(.W(W)) u_dig (
      .clk   (clk),
      .rst   (rst),
      .clr   (clr_i),
      .inc   (chain[g]),
      .q     (cnt_q[g*W +: W]),
      .carry (chain[g+1])
    );
  end

  swatch_lap_unit #(.CW(CW)) u_lap (
    .clk       (clk),
    .rst       (rst),
    .lap       (lap_i),
    .wrap      (wrap),
    .hi_read   (hi_read),
    .carry_clr (carry_clr_i),
    .cnt       (cnt_q),
    .lap_buf   (lap_buf_q),
    .renew     (renew_o),
    .carry_req (carry_req_o)
  );

  swatch_read_stage #(.DIGITS(DIGITS), .W(W), .SEL_W(SEL_W)) u_rd (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (rd_en_i),
    .rd_src  (rd_src_i),
    .rd_sel  (rd_sel_i),
    .live    (cnt_q),
    .lap_buf (lap_buf_q),
    .rd_data (rd_data_o),
    .hi_read (hi_read)
  );

  always_ff @(posedge clk) begin
    if (rst)            irq_o <= 1'b0;
    else if (wrap)      irq_o <= 1'b1;
    else if (irq_clr_i) irq_o <= 1'b0;
  end
endmodule

// File: rtl/swatch_lap_chk.sv
module swatch_lap_chk #(
  parameter int DIGITS = 3,
  parameter int W      = 4
) (
  input logic                clk,
  input logic                rst,
  input logic                tick_i,
  input logic                run_i,
  input logic                clr_i,
  input logic                lap_i,
  input logic                irq_clr_i,
  input logic [DIGITS*W-1:0] cnt_q,
  input logic [DIGITS*W-1:0] lap_buf_q,
  input logic                renew_o,
  input logic                carry_req_o,
  input logic                irq_o
);
  localparam logic [DIGITS*W-1:0] ALL_NINE = {DIGITS{W'(9)}};

  logic wrap_tick;
  assign wrap_tick = tick_i && run_i && !clr_i && (cnt_q == ALL_NINE);

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (!irq_o && !renew_o && !carry_req_o && cnt_q == '0));

  // R3
  paused_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!run_i && !clr_i) |=> $stable(cnt_q));

  // R4
  clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (cnt_q == '0));

  // R4
  clear_keeps_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !irq_clr_i) |=> (irq_o == $past(irq_o)));

  // R5
  wrap_irq_chk: assert property (@(posedge clk) disable iff (rst)
    wrap_tick |=> irq_o);

  // R6
  lap_copy_chk: assert property (@(posedge clk) disable iff (rst)
    lap_i |=> (lap_buf_q == $past(cnt_q)));

  // R7
  lap_renew_chk: assert property (@(posedge clk) disable iff (rst)
    lap_i |=> renew_o);

  // R8
  lap_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (lap_i && wrap_tick) |=> carry_req_o);
endmodule

bind swatch_lap swatch_lap_chk #(.DIGITS(DIGITS), .W(W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .tick_i      (tick_i),
  .run_i       (run_i),
  .clr_i       (clr_i),
  .lap_i       (lap_i),
  .irq_clr_i   (irq_clr_i),
  .cnt_q       (cnt_q),
  .lap_buf_q   (lap_buf_q),
  .renew_o     (renew_o),
  .carry_req_o (carry_req_o),
  .irq_o       (irq_o)
);

// File: tb/test_swatch_lap.sv
module test_swatch_lap;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst;
  logic tick_i, run_i, clr_i, lap_i, irq_clr_i, carry_clr_i;
  logic rd_en_i, rd_src_i;
  logic [1:0] rd_sel_i;
  logic [3:0] rd_data_o;
  logic renew_o, carry_req_o, irq_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  int         m_cnt;
  int         m_buf;
  logic [7:0] m_shadow;
  logic [3:0] m_rd;
  logic       m_renew, m_carry, m_irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  swatch_lap i_swatch_lap (
    .clk(clk), .rst(rst), .tick_i(tick_i), .run_i(run_i), .clr_i(clr_i),
    .lap_i(lap_i), .irq_clr_i(irq_clr_i), .carry_clr_i(carry_clr_i),
    .rd_en_i(rd_en_i), .rd_src_i(rd_src_i), .rd_sel_i(rd_sel_i),
    .rd_data_o(rd_data_o), .renew_o(renew_o), .carry_req_o(carry_req_o),
    .irq_o(irq_o)
  );

  function automatic logic [11:0] to_bcd(int v);
    return {4'(v / 100), 4'((v / 10) % 10), 4'(v % 10)};
  endfunction

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    check({tag, " rd_data"}, rd_data_o, m_rd);
    check({tag, " renew"}, renew_o, m_renew);
    check({tag, " carry_req"}, carry_req_o, m_carry);
    check({tag, " irq"}, irq_o, m_irq);
  endtask

  task automatic cyc(input logic tk, rn, cl, lp, ic, cc, re, rs,
                     input logic [1:0] sl, input string tag);
    logic [11:0] src;
    logic        wr;
    tick_i = tk; run_i = rn; clr_i = cl; lap_i = lp; irq_clr_i = ic;
    carry_clr_i = cc; rd_en_i = re; rd_src_i = rs; rd_sel_i = sl;
    @(posedge clk);
    src = rs ? to_bcd(m_buf) : to_bcd(m_cnt);
    wr  = tk && rn && !cl && (m_cnt == 999);
    if (re) begin
      case (sl)
        2'd0: m_rd = src[3:0];
        2'd1: m_rd = m_shadow[3:0];
        2'd2: m_rd = m_shadow[7:4];
        default: m_rd = 4'd0;
      endcase
      if (sl == 2'd0) m_shadow = src[11:4];
    end
    if (lp) m_renew = 1'b1;
    else if (re && rs && sl == 2'd2) m_renew = 1'b0;
    if (lp && wr) m_carry = 1'b1;
    else if (cc) m_carry = 1'b0;
    if (wr) m_irq = 1'b1;
    else if (ic) m_irq = 1'b0;
    if (lp) m_buf = m_cnt;
    if (cl) m_cnt = 0;
    else if (tk && rn) m_cnt = (m_cnt + 1) % 1000;
    @(negedge clk);
    check_all(tag);
  endtask

  task automatic idle(string tag);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 2'd0, tag);
  endtask

  task automatic rd(logic src, logic [1:0] sel, string tag);
    cyc(0, 0, 0, 0, 0, 0, 1, src, sel, tag);
  endtask

  task automatic run_to(int target, string tag);
    while (m_cnt != target) cyc(1, 1, 0, 0, 0, 0, 0, 0, 2'd0, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst = 1'b1;
    tick_i = 0; run_i = 0; clr_i = 0; lap_i = 0; irq_clr_i = 0;
    carry_clr_i = 0; rd_en_i = 0; rd_src_i = 0; rd_sel_i = 0;
    m_cnt = 0; m_buf = 0; m_shadow = 0; m_rd = 0;
    m_renew = 0; m_carry = 0; m_irq = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check_all("R1 reset");
    rd(1, 2'd0, "R1 buffer zero");
    rd(0, 2'd0, "R1 count zero");

    // R2: BCD count with carry across digit 0
    repeat (15) cyc(1, 1, 0, 0, 0, 0, 0, 0, 2'd0, "R2 count");
    rd(0, 2'd0, "R2 digit0");
    check("R2 digit0 is 5", rd_data_o, 5);
    rd(0, 2'd1, "R2 digit1");
    check("R2 digit1 is 1", rd_data_o, 1);
    rd(0, 2'd2, "R2 digit2");
    rd(0, 2'd3, "R9 unused select");

    // R3: paused ticks ignored; R6 lap still works while paused
    repeat (7) cyc(1, 0, 0, 0, 0, 0, 0, 0, 2'd0, "R3 paused");
    cyc(1, 0, 0, 1, 0, 0, 0, 0, 2'd0, "R6 lap paused");
    rd(1, 2'd0, "R6 buffer digit0");
    check("R6 buffer digit0 is 5", rd_data_o, 5);
    rd(1, 2'd1, "R6 buffer digit1");
    idle("R10 hold");
    idle("R10 hold");
    rd(1, 2'd2, "R7 top read clears renew");
    check("R7 renew cleared", renew_o, 0);

    // R7 set wins over top-nibble read
    rd(1, 2'd0, "R9 latch");
    cyc(0, 1, 0, 1, 0, 0, 1, 1, 2'd2, "R7 lap beats clear");

    // R9 snapshot: latch, advance across carries, read upper nibbles
    run_to(97, "R2 advance");
    rd(0, 2'd0, "R9 latch live");
    repeat (5) cyc(1, 1, 0, 0, 0, 0, 0, 0, 2'd0, "R2 advance");
    rd(0, 2'd1, "R9 shadow digit1");
    check("R9 shadow digit1 is 9", rd_data_o, 9);
    rd(0, 2'd2, "R9 shadow digit2");
    check("R9 shadow digit2 is 0", rd_data_o, 0);

    // R5/R8: lap on the wrapping tick
    run_to(999, "R2 advance");
    cyc(1, 1, 0, 1, 0, 0, 0, 0, 2'd0, "R8 lap on wrap");
    check("R5 irq after wrap", irq_o, 1);
    rd(1, 2'd0, "R8 captured 999 digit0");
    check("R8 captured digit0 is 9", rd_data_o, 9);
    cyc(1, 1, 1, 0, 0, 0, 0, 0, 2'd0, "R4 clear beats tick, irq kept");
    check("R4 irq kept", irq_o, 1);
    rd(0, 2'd0, "R4 count zero");
    cyc(0, 0, 0, 0, 1, 1, 0, 0, 2'd0, "R5 R8 flag clears");

    // R5 set wins over clear
    run_to(999, "R2 advance");
    cyc(1, 1, 0, 0, 1, 0, 0, 0, 2'd0, "R5 wrap beats irq clear");
    check("R5 irq still set", irq_o, 1);
    run_to(999, "R2 advance");
    cyc(1, 1, 0, 1, 0, 1, 0, 0, 2'd0, "R8 set beats clear");
    cyc(0, 0, 0, 0, 1, 1, 0, 0, 2'd0, "R5 R8 flag clears");

    // Random mix
    for (int i = 0; i < 6000; i++) begin
      cyc(($urandom % 4) != 0, ($urandom % 8) != 0, ($urandom % 97) == 0,
          ($urandom % 13) == 0, ($urandom % 29) == 0, ($urandom % 31) == 0,
          ($urandom % 3) == 0, $urandom % 2, 2'($urandom % 4),
          "R2 R9 random mix");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule